// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window index and the per-window invalid mask of a 32-bit processor whose general registers are arranged as a ring of overlapping windows. A procedure entry moves the index down one window and a procedure exit moves it up one. Both moves wrap around the ring. Before any move is committed, the mask bit of the target window is tested. A marked window stops the move and raises a one-cycle trap request. The trap-handling logic is expected to spill or refill the register file and then retry.

The block also owns the processor status word. A write loads the condition codes, the FPU enable, the interrupt level, the privilege bits, the trap enable and the window index from a 32-bit value. A write that names a window beyond the ring is refused with an illegal-instruction trap. A return-from-trap command is refused the same way when traps are already enabled. When allowed, it moves up one window, enables traps and restores the saved privilege. A read strobe returns the assembled status word one cycle later.

Commands arrive as single-cycle strobes on plain control pins. Trap requests are the only outputs that leave the block toward trap vectoring.

Top module: `wnd_ptr_ctrl`

## Requirements
- R1: After reset the window index is 0, the invalid mask is 0, the supervisor bit is 1, the trap enable bit is 0, and no trap output is high.
- R2: A save strobe moves the window index to index−1, or to NWIN−1 from index 0. The change is visible on `cwp_o` in the cycle after the strobe.
- R3: A save whose target window has its mask bit set leaves the index unchanged and raises `trap_ovf` for one cycle.
- R4: A restore strobe moves the window index to index+1, or to 0 from NWIN−1.
- R5: A restore whose target window has its mask bit set leaves the index unchanged and raises `trap_unf` for one cycle.
- R6: A return-from-trap while the trap enable bit is 1 raises `trap_ill` and changes nothing.
- R7: A return-from-trap while the trap enable bit is 0 applies the restore move and its mask check. On success it sets the trap enable bit to 1 and copies the previous-supervisor bit into the supervisor bit. When the mask check fails it raises `trap_unf` and changes nothing, trap enable included.
- R8: A status write whose bits 4:0 are ≥ NWIN raises `trap_ill` and changes nothing. Any other status write loads every status field from the written word, and the other bits of the word are ignored.
- R9: Read word layout: bits 31:24 hold IMPL_ID, bits 23:20 the condition codes, bit 12 the FPU enable, bits 11:8 the interrupt level, bit 7 the supervisor bit, bit 6 the previous-supervisor bit, bit 5 the trap enable bit, bits 4:0 the window index, and every other bit is 0. `psr_rvalid` is high in the cycle after `cmd_rpsr`, and the word shows the state from before any command of that same cycle.
- R10: When several commands are strobed together, only the one of highest priority acts: return-from-trap, then status write, then save, then restore.
- R11: At most one of `trap_ovf`, `trap_unf` and `trap_ill` is high in any cycle, and each is high only in the cycle after the command that caused it.
- R12: `wim_we` loads `wim_data` into the invalid mask. Bit k marks window k. A move issued in the same cycle is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_save | input | 1 | Save (window down) strobe |
| cmd_restore | input | 1 | Restore (window up) strobe |
| cmd_rett | input | 1 | Return-from-trap strobe |
| cmd_wpsr | input | 1 | Status word write strobe |
| cmd_rpsr | input | 1 | Status word read strobe |
| wpsr_data | input | 32 | Word for a status write |
| wim_we | input | 1 | Invalid mask write strobe |
| wim_data | input | NWIN | New invalid mask |
| cwp_o | output | 5 | Current window index |
| wim_o | output | NWIN | Current invalid mask |
| trap_ovf | output | 1 | Window overflow trap request |
| trap_unf | output | 1 | Window underflow trap request |
| trap_ill | output | 1 | Illegal instruction trap request |
| psr_rdata | output | 32 | Assembled status word |
| psr_rvalid | output | 1 | Read data valid |

## Verification
Two things can happen in the same cycle here. A status read can arrive together with a command that changes state, and several commands can arrive together. The bench strobes a read with a save and expects the read word to hold the window index from before the move, while `cwp_o` shows the new one. It also strobes all four commands, then a status write with a save, then a save with a restore. In each case only the highest-priority command should have acted, and this is judged from the resulting window index, the trap outputs and the trap enable bit seen on a later read.

// File: rtl/wnd_pkg.sv
package wnd_pkg;
  // status word field positions (read and write share them)
  localparam int POS_ICC = 20;
  localparam int POS_EF  = 12;
  localparam int POS_PIL = 8;
  localparam int POS_S   = 7;
  localparam int POS_PS  = 6;
  localparam int POS_ET  = 5;
  localparam int CWP_FW  = 5;

  typedef struct packed {
    logic [3:0]        icc;
    logic              ef;
    logic [3:0]        pil;
    logic              s;
    logic              ps;
    logic              et;
    logic [CWP_FW-1:0] cwp;
  } psw_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RETT, OP_WPSR, OP_SAVE, OP_RESTORE
  } wop_e;
endpackage

// File: rtl/wnd_step.sv
module wnd_step #(
  parameter int   NWIN = 8,
  parameter logic UP   = 1'b1
) (
  input  logic [$clog2(NWIN)-1:0] cur,
  input  logic [NWIN-1:0]         mask,
  output logic [$clog2(NWIN)-1:0] nxt,
  output logic                    hit
);
  localparam int IW = $clog2(NWIN);
  localparam logic [IW-1:0] LAST = IW'(NWIN - 1);

  generate
    if (UP) begin : g_up
      assign nxt = (cur == LAST) ? '0 : cur + 1'b1;
    end else begin : g_down
      assign nxt = (cur == '0) ? LAST : cur - 1'b1;
    end
  endgenerate

  assign hit = mask[nxt];

  always_comb begin
    p_step_range_r2: assert (int'(nxt) < NWIN);
  end
endmodule

// File: rtl/psw_pack.sv
module psw_pack import wnd_pkg::*; #(
  parameter logic [7:0] IMPL_ID = 8'h15
) (
  input  psw_t        st,
  output logic [31:0] word
);
  always_comb begin
    word                 = '0;
    word[31:24]          = IMPL_ID;
    word[POS_ICC +: 4]   = st.icc;
    word[POS_EF]         = st.ef;
    word[POS_PIL +: 4]   = st.pil;
    word[POS_S]          = st.s;
    word[POS_PS]         = st.ps;
    word[POS_ET]         = st.et;
    word[CWP_FW-1:0]     = st.cwp;
  end
endmodule

// File: rtl/wnd_ptr_ctrl.sv
module wnd_ptr_ctrl import wnd_pkg::*; #(
  parameter int         NWIN    = 8,
  parameter logic [7:0] IMPL_ID = 8'h15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_save,
  input  logic            cmd_restore,
  input  logic            cmd_rett,
  input  logic            cmd_wpsr,
  input  logic            cmd_rpsr,
  input  logic [31:0]     wpsr_data,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_data,
  output logic [4:0]      cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            trap_ovf,
  output logic            trap_unf,
  output logic            trap_ill,
  output logic [31:0]     psr_rdata,
  output logic            psr_rvalid
);
  localparam int IW = $clog2(NWIN);
  localparam logic [5:0] NW6 = 6'(NWIN);

  logic [IW-1:0]   cwp_q;
  logic [NWIN-1:0] wim_q;
  logic [3:0]      icc_q, pil_q;
  logic            ef_q, s_q, ps_q, et_q;

  logic [IW-1:0] up_nxt, dn_nxt;
  logic          up_hit, dn_hit;
  logic          wr_bad;
  wop_e          op;
  psw_t          cur_st;
  logic [31:0]   cur_word;
  logic          unused_bits;

  wnd_step #(.NWIN(NWIN), .UP(1'b1)) u_up (
    .cur(cwp_q), .mask(wim_q), .nxt(up_nxt), .hit(up_hit));
  wnd_step #(.NWIN(NWIN), .UP(1'b0)) u_dn (
    .cur(cwp_q), .mask(wim_q), .nxt(dn_nxt), .hit(dn_hit));

  assign cur_st = {icc_q, ef_q, pil_q, s_q, ps_q, et_q, CWP_FW'(cwp_q)};
  psw_pack #(.IMPL_ID(IMPL_ID)) u_pack (.st(cur_st), .word(cur_word));

  assign wr_bad      = {1'b0, wpsr_data[4:0]} >= NW6;
  assign unused_bits = ^{wpsr_data[31:24], wpsr_data[19:13]};

  always_comb begin
    if (cmd_rett)          op = OP_RETT;
    else if (cmd_wpsr)     op = OP_WPSR;
    else if (cmd_save)     op = OP_SAVE;
    else if (cmd_restore)  op = OP_RESTORE;
    else                   op = OP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q      <= '0;
      wim_q      <= '0;
      icc_q      <= '0;
      pil_q      <= '0;
      ef_q       <= 1'b0;
      s_q        <= 1'b1;
      ps_q       <= 1'b0;
      et_q       <= 1'b0;
      trap_ovf   <= 1'b0;
      trap_unf   <= 1'b0;
      trap_ill   <= 1'b0;
      psr_rdata  <= '0;
      psr_rvalid <= 1'b0;
    end else begin
      trap_ovf   <= 1'b0;
      trap_unf   <= 1'b0;
      trap_ill   <= 1'b0;
      psr_rvalid <= cmd_rpsr;
      if (cmd_rpsr) psr_rdata <= cur_word;
      if (wim_we)   wim_q <= wim_data;
      case (op)
        OP_RETT: begin
          if (et_q)        trap_ill <= 1'b1;
          else if (up_hit) trap_unf <= 1'b1;
          else begin
            cwp_q <= up_nxt;
            et_q  <= 1'b1;
            s_q   <= ps_q;
          end
        end
        OP_WPSR: begin
          if (wr_bad) trap_ill <= 1'b1;
          else begin
            icc_q <= wpsr_data[POS_ICC +: 4];
            ef_q  <= wpsr_data[POS_EF];
            pil_q <= wpsr_data[POS_PIL +: 4];
            s_q   <= wpsr_data[POS_S];
            ps_q  <= wpsr_data[POS_PS];
            et_q  <= wpsr_data[POS_ET];
            cwp_q <= wpsr_data[IW-1:0];
          end
        end
        OP_SAVE: begin
          if (dn_hit) trap_ovf <= 1'b1;
          else        cwp_q    <= dn_nxt;
        end
        OP_RESTORE: begin
          if (up_hit) trap_unf <= 1'b1;
          else        cwp_q    <= up_nxt;
        end
        default: ;
      endcase
    end
  end

  assign cwp_o = 5'(cwp_q);
  assign wim_o = wim_q;

  // ---------------- assertions ----------------
  p_cwp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_o) < NWIN);
  p_trap_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ovf, trap_unf, trap_ill}));
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ovf |-> cwp_o == $past(cwp_o));
  p_unf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_unf |-> ($stable(cwp_o) && $stable(et_q)));
  p_ill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ill |-> ($stable(cwp_o) && $stable(et_q)));
  p_rett_et_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rett |=> (et_q || trap_unf));
  p_save_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_save && !cmd_rett && !cmd_wpsr) |=> (trap_ovf || cwp_o != $past(cwp_o)));
  p_read_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rpsr |=> psr_rvalid);
endmodule

// File: tb/wnd_ptr_ctrl_tb.sv
module wnd_ptr_ctrl_tb_top;
  localparam int         NWIN = 8;
  localparam logic [7:0] IMPL = 8'h15;
  localparam int         NV   = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_save = 0, cmd_restore = 0, cmd_rett = 0, cmd_wpsr = 0, cmd_rpsr = 0;
  logic [31:0] wpsr_data = '0;
  logic wim_we = 0;
  logic [NWIN-1:0] wim_data = '0;
  logic [4:0] cwp_o;
  logic [NWIN-1:0] wim_o;
  logic trap_ovf, trap_unf, trap_ill;
  logic [31:0] psr_rdata;
  logic psr_rvalid;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  wnd_ptr_ctrl #(.NWIN(NWIN), .IMPL_ID(IMPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
    .cmd_rett(cmd_rett), .cmd_wpsr(cmd_wpsr), .cmd_rpsr(cmd_rpsr),
    .wpsr_data(wpsr_data), .wim_we(wim_we), .wim_data(wim_data),
    .cwp_o(cwp_o), .wim_o(wim_o), .trap_ovf(trap_ovf), .trap_unf(trap_unf),
    .trap_ill(trap_ill), .psr_rdata(psr_rdata), .psr_rvalid(psr_rvalid));

  // {cmd[3:0]={rett,wpsr,save,restore}, wim_we, data[31:0], exp_cwp[4:0], exp_trap[2:0]={ill,unf,ovf}, exp_et}
  localparam logic [45:0] VEC [NV] = '{
    {4'b0010, 1'b0, 32'h0,        5'd7, 3'b000, 1'b0},  // R2 wrap down
    {4'b0010, 1'b0, 32'h0,        5'd6, 3'b000, 1'b0},  // R2
    {4'b0001, 1'b0, 32'h0,        5'd7, 3'b000, 1'b0},  // R4
    {4'b0001, 1'b0, 32'h0,        5'd0, 3'b000, 1'b0},  // R4 wrap up
    {4'b0000, 1'b1, 32'h2,        5'd0, 3'b000, 1'b0},  // R12 mask=0x02
    {4'b0001, 1'b0, 32'h0,        5'd0, 3'b010, 1'b0},  // R5 blocked
    {4'b0010, 1'b0, 32'h0,        5'd7, 3'b000, 1'b0},  // R2
    {4'b0000, 1'b1, 32'h40,       5'd7, 3'b000, 1'b0},  // R12 mask=0x40
    {4'b0010, 1'b0, 32'h0,        5'd7, 3'b001, 1'b0},  // R3 blocked
    {4'b1000, 1'b0, 32'h0,        5'd0, 3'b000, 1'b1},  // R7 ok
    {4'b1000, 1'b0, 32'h0,        5'd0, 3'b100, 1'b1},  // R6 et=1
    {4'b0100, 1'b0, 32'h9,        5'd0, 3'b100, 1'b1},  // R8 bad cwp
    {4'b0100, 1'b0, 32'h00F00F43, 5'd3, 3'b000, 1'b0},  // R8 load
    {4'b1111, 1'b0, 32'h5,        5'd4, 3'b000, 1'b1},  // R10 rett wins
    {4'b0110, 1'b0, 32'h2,        5'd2, 3'b000, 1'b0},  // R10 wpsr wins
    {4'b0011, 1'b0, 32'h0,        5'd1, 3'b000, 1'b0},  // R10 save wins
    {4'b1000, 1'b0, 32'h0,        5'd2, 3'b000, 1'b1}   // R7
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [3:0] c, logic we, logic [31:0] d, logic rd);
    @(negedge clk);
    {cmd_rett, cmd_wpsr, cmd_save, cmd_restore} = c;
    cmd_rpsr = rd; wim_we = we; wpsr_data = d; wim_data = d[NWIN-1:0];
    @(posedge clk);
    @(negedge clk);
    {cmd_rett, cmd_wpsr, cmd_save, cmd_restore} = '0;
    cmd_rpsr = 0; wim_we = 0; wpsr_data = '0; wim_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 wim", 32'(wim_o), 0);
    chk("R1 traps", 32'({trap_ill, trap_unf, trap_ovf}), 0);
    run(4'b0000, 1'b0, 32'h0, 1'b1);
    chk("R1 R9 reset word", psr_rdata, {IMPL, 24'h000080});

    // vector table
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][45:42], VEC[i][41], VEC[i][40:9], 1'b0);
      chk($sformatf("R2-vec%0d cwp", i), 32'(cwp_o), 32'(VEC[i][8:4]));
      chk($sformatf("R11 vec%0d traps", i), 32'({trap_ill, trap_unf, trap_ovf}),
          32'(VEC[i][3:1]));
      run(4'b0000, 1'b0, 32'h0, 1'b1);
      chk($sformatf("R7 vec%0d et", i), 32'(psr_rdata[5]), 32'(VEC[i][0]));
      chk($sformatf("R11 vec%0d trap cleared", i),
          32'({trap_ill, trap_unf, trap_ovf}), 0);
    end

    // R8 R9: junk bits ignored, full layout on read
    run(4'b0100, 1'b0, 32'hFFAFFAA5, 1'b0);
    chk("R8 cwp", 32'(cwp_o), 5);
    run(4'b0000, 1'b0, 32'h0, 1'b1);
    chk("R9 layout", psr_rdata, {IMPL, 24'hA01AA5});
    chk("R9 rvalid", 32'(psr_rvalid), 1);

    // R9: read together with save shows pre-move state
    run(4'b0010, 1'b0, 32'h0, 1'b1);
    chk("R9 read old cwp", 32'(psr_rdata[4:0]), 5);
    chk("R9 save moved", 32'(cwp_o), 4);

    // R7: success copies previous-supervisor into supervisor
    run(4'b0100, 1'b0, 32'h00000041, 1'b0);
    run(4'b1000, 1'b0, 32'h0, 1'b0);
    chk("R7 cwp", 32'(cwp_o), 2);
    run(4'b0000, 1'b0, 32'h0, 1'b1);
    chk("R7 word", psr_rdata, {IMPL, 24'h0000E2});

    // R7: blocked return changes nothing (mask bit 6 set)
    run(4'b0100, 1'b0, 32'h00000045, 1'b0);
    run(4'b1000, 1'b0, 32'h0, 1'b0);
    chk("R7 blocked trap", 32'({trap_ill, trap_unf, trap_ovf}), 32'b010);
    run(4'b0000, 1'b0, 32'h0, 1'b1);
    chk("R7 blocked word", psr_rdata, {IMPL, 24'h000045});

    // R12 R1: mask cleared by reset
    run(4'b0000, 1'b1, 32'h80, 1'b0);
    chk("R12 wim", 32'(wim_o), 32'h80);
    do_reset();
    chk("R1 wim after reset", 32'(wim_o), 0);
    run(4'b0010, 1'b0, 32'h0, 1'b0);
    chk("R1 save after reset", 32'(cwp_o), 7);
    chk("R1 no trap", 32'(trap_ovf), 0);

    finish_run();
  end
endmodule